// File: doc/BRIEF.md
# Programmed-I/O Playback Byte Assembler

This block sits between a host that pushes audio playback data one byte at a time through a single 8-bit write port and a DAC-side consumer that takes whole samples. The host watches four status outputs: which byte it should send next (upper or lower half of a channel), which channel that byte belongs to, whether the sample buffer is free, and whether the DAC last found no complete sample. It then writes bytes until the sample is complete. The block supports mono or stereo samples, each with 8-bit or 16-bit channels.

The DAC side presents a one-cycle request strobe when it wants a sample. The request is the ready half of the output handshake, and a complete sample in the buffer is the valid half (`buf_stale` low). A request that finds a complete sample moves it into the output register and frees the buffer. A request that finds no complete sample is an underrun. In that case the output register keeps and re-presents the previous sample, the partial bytes are discarded, and the underrun flag is raised. The DAC can never be held off, so back-pressure reaches only the host. While the buffer holds a complete sample, host writes are dropped, and while `init_active` is high, every host write is dropped.

Top module: `pio_play_asm`

## Requirements
- R1: After reset `buf_stale` is 1, `underrun` is 0, `play_data` is all zero, and the byte pointer is at the first byte of a sample.
- R2: In 16-bit stereo the bytes are taken in the order left-low, left-high, right-low, right-high. In 8-bit stereo the order is left, then right. In 16-bit mono it is low, then high, and 8-bit mono takes a single byte.
- R3: `need_upper` reads 0 when a low byte is expected and 1 when a high byte is expected. It always reads 1 in either 8-bit mode.
- R4: `need_left` reads 1 when a left-channel byte is expected and 0 for a right-channel byte. It always reads 1 in mono. While the buffer is full, both flags show the first byte of the next sample.
- R5: Once the last byte of a sample is written, `buf_stale` drops to 0. It stays 0 and every further host write is ignored until the next `dac_req`.
- R6: A `dac_req` while `buf_stale` is 0 loads the assembled sample into `play_data` on the next cycle, sets `buf_stale` to 1 and clears `underrun`.
- R7: A `dac_req` while `buf_stale` is 1 leaves `play_data` unchanged, sets `underrun`, discards any partial bytes and returns the pointer to the first byte.
- R8: While `init_active` is 1, host writes have no effect on the pointer, the flags or the stored bytes.
- R9: `play_data` is {left[15:0], right[15:0]}. In 8-bit modes the byte sits in bits [7:0] of its channel with bits [15:8] zero. In mono the right field is zero.
- R10: A host write in the same cycle as `dac_req` is dropped.
- R11: `play_data` changes only in the cycle after a `dac_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_active | input | 1 | High while initialization is in progress; locks out host writes |
| stereo | input | 1 | 1 = stereo, 0 = mono |
| wide | input | 1 | 1 = 16-bit channels, 0 = 8-bit channels |
| wr_en | input | 1 | Host write strobe, one cycle per byte |
| wr_data | input | 8 | Host write byte |
| dac_req | input | 1 | DAC sample request strobe |
| play_data | output | 32 | Sample presented to the DAC, {left, right} |
| need_upper | output | 1 | 1 = high byte expected next, 0 = low byte |
| need_left | output | 1 | 1 = left channel expected next, 0 = right |
| buf_stale | output | 1 | 1 = buffer free for writes, 0 = complete sample held |
| underrun | output | 1 | Last DAC request found no complete sample |

## Verification
A byte pointer that advances wrongly or fails to reset shows up on `need_upper` and `need_left` in the same cycle as the faulty register update. It therefore appears before the next host write. Bytes routed to the wrong slot stay inside the block until the next DAC request, and then appear as a misplaced byte in `play_data` one cycle after that request. A completion flag that is set or cleared at the wrong time shows on `buf_stale` immediately. It also shows on `underrun`, and on whether `play_data` updates, after the next request.

// File: rtl/pio_play_asm_pkg.sv
package pio_play_asm_pkg;

  // Byte position inside a sample, decoded from the pointer and the mode.
  typedef struct packed {
    logic chan_right;
    logic hi_byte;
  } slot_t;

  function automatic slot_t slot_of(input logic [1:0] idx, input logic wide);
    slot_t s;
    if (wide) begin
      s.chan_right = idx[1];
      s.hi_byte    = idx[0];
    end else begin
      s.chan_right = idx[0];
      s.hi_byte    = 1'b0;
    end
    return s;
  endfunction

  function automatic logic [1:0] last_idx(input logic stereo, input logic wide);
    logic [1:0] r;
    if (stereo && wide)      r = 2'd3;
    else if (stereo || wide) r = 2'd1;
    else                     r = 2'd0;
    return r;
  endfunction

endpackage

// File: rtl/pio_play_tracker.sv
module pio_play_tracker
  import pio_play_asm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_active,
  input  logic       stereo,
  input  logic       wide,
  input  logic       wr_en,
  input  logic       dac_req,
  output logic       accept,
  output logic [1:0] idx,
  output logic       full,
  output logic       need_upper,
  output logic       need_left
);

  slot_t cur;

  // A request wins over a write in the same cycle; a full buffer drops writes.
  assign accept = wr_en && !init_active && !full && !dac_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx  <= '0;
      full <= 1'b0;
    end else if (dac_req) begin
      idx  <= '0;
      full <= 1'b0;
    end else if (accept) begin
      if (idx == last_idx(stereo, wide)) begin
        idx  <= '0;
        full <= 1'b1;
      end else begin
        idx  <= idx + 2'd1;
      end
    end
  end

  always_comb begin
    cur        = slot_of(idx, wide);
    need_upper = wide ? cur.hi_byte : 1'b1;
    need_left  = stereo ? !cur.chan_right : 1'b1;
  end

endmodule

// File: rtl/pio_play_stage.sv
module pio_play_stage
  import pio_play_asm_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CH_W  = 2 * BYTE_W,
  localparam int SMP_W = 2 * CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [1:0]        idx,
  input  logic              stereo,
  input  logic              wide,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [SMP_W-1:0]  sample
);

  slot_t             tgt;
  logic [CH_W-1:0]   ch_q [2];

  assign tgt = slot_of(idx, wide);

  // One holding register per channel; index 0 = left, 1 = right.
  for (genvar c = 0; c < 2; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ch_q[c] <= '0;
      end else if (accept && (tgt.chan_right == c[0])) begin
        if (!wide) begin
          ch_q[c] <= {{BYTE_W{1'b0}}, wr_data};
        end else if (tgt.hi_byte) begin
          ch_q[c][CH_W-1:BYTE_W] <= wr_data;
        end else begin
          ch_q[c][BYTE_W-1:0] <= wr_data;
        end
      end
    end
  end

  assign sample = {ch_q[0], stereo ? ch_q[1] : {CH_W{1'b0}}};

endmodule

// File: rtl/pio_play_out.sv
module pio_play_out #(
  parameter int SMP_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dac_req,
  input  logic             full,
  input  logic [SMP_W-1:0] sample,
  output logic [SMP_W-1:0] play_data,
  output logic             underrun
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      play_data <= '0;
      underrun  <= 1'b0;
    end else if (dac_req) begin
      if (full) begin
        play_data <= sample;
        underrun  <= 1'b0;
      end else begin
        underrun  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pio_play_asm.sv
module pio_play_asm #(
  parameter int BYTE_W = 8,
  localparam int CH_W  = 2 * BYTE_W,
  localparam int SMP_W = 2 * CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_active,
  input  logic              stereo,
  input  logic              wide,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              dac_req,
  output logic [SMP_W-1:0]  play_data,
  output logic              need_upper,
  output logic              need_left,
  output logic              buf_stale,
  output logic              underrun
);

  logic             accept;
  logic [1:0]       idx;
  logic             full;
  logic [SMP_W-1:0] sample;

  pio_play_tracker u_trk (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_active (init_active),
    .stereo      (stereo),
    .wide        (wide),
    .wr_en       (wr_en),
    .dac_req     (dac_req),
    .accept      (accept),
    .idx         (idx),
    .full        (full),
    .need_upper  (need_upper),
    .need_left   (need_left)
  );

  pio_play_stage #(.BYTE_W(BYTE_W)) u_stg (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .idx     (idx),
    .stereo  (stereo),
    .wide    (wide),
    .wr_data (wr_data),
    .sample  (sample)
  );

  pio_play_out #(.SMP_W(SMP_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .dac_req   (dac_req),
    .full      (full),
    .sample    (sample),
    .play_data (play_data),
    .underrun  (underrun)
  );

  assign buf_stale = !full;

endmodule

// File: rtl/pio_play_asm_chk.sv
module pio_play_asm_chk #(
  parameter int SMP_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             init_active,
  input logic             stereo,
  input logic             wide,
  input logic             dac_req,
  input logic [SMP_W-1:0] play_data,
  input logic             need_upper,
  input logic             need_left,
  input logic             buf_stale,
  input logic             underrun
);

  a_r3_narrow_upper: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |-> need_upper);

  a_r4_mono_left: assert property (@(posedge clk) disable iff (!rst_n)
    !stereo |-> need_left);

  a_r5_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_stale && !dac_req |=> !buf_stale);

  a_r6_take_sample: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_stale && dac_req |=> buf_stale && !underrun);

  a_r7_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    buf_stale && dac_req |=> underrun && $stable(play_data) && buf_stale);

  a_r8_init_lock: assert property (@(posedge clk) disable iff (!rst_n)
    init_active && buf_stale && !dac_req |=> buf_stale);

  a_r11_play_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_req |=> $stable(play_data));

endmodule

bind pio_play_asm pio_play_asm_chk #(.SMP_W(SMP_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .init_active (init_active),
  .stereo      (stereo),
  .wide        (wide),
  .dac_req     (dac_req),
  .play_data   (play_data),
  .need_upper  (need_upper),
  .need_left   (need_left),
  .buf_stale   (buf_stale),
  .underrun    (underrun)
);

// File: tb/sim_pio_play_asm.sv
`timescale 1ns/1ps
module sim_pio_play_asm;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_active = 1'b0;
  logic        stereo = 1'b0;
  logic        wide = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        dac_req = 1'b0;
  logic [31:0] play_data;
  logic        need_upper, need_left, buf_stale, underrun;

  int checks = 0;
  int errors = 0;
  logic [31:0] last_play = '0;

  always #2.5 clk = ~clk;

  pio_play_asm u0 (
    .clk(clk), .rst_n(rst_n), .init_active(init_active), .stereo(stereo),
    .wide(wide), .wr_en(wr_en), .wr_data(wr_data), .dac_req(dac_req),
    .play_data(play_data), .need_upper(need_upper), .need_left(need_left),
    .buf_stale(buf_stale), .underrun(underrun)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_flags(input logic u, input logic l, input logic s, input string tag);
    chk({need_upper, need_left, buf_stale} == {u, l, s}, tag,
        {29'd0, need_upper, need_left, buf_stale}, {29'd0, u, l, s});
  endtask

  task automatic host_wr(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic dac_pulse();
    @(negedge clk); dac_req = 1'b1;
    @(negedge clk); dac_req = 1'b0;
  endtask

  task automatic set_mode(input logic st, input logic wd);
    @(negedge clk); stereo = st; wide = wd;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(buf_stale === 1'b1 && underrun === 1'b0, "R1 reset flags",
        {30'd0, buf_stale, underrun}, 32'h2);
    chk(play_data === 32'h0, "R1 reset play_data", play_data, 32'h0);
    chk_flags(1'b1, 1'b1, 1'b1, "R1 reset pointer at first byte");
  endtask

  task automatic t_mono8();
    set_mode(1'b0, 1'b0);
    chk_flags(1'b1, 1'b1, 1'b1, "R3 R4 mono8 first byte flags");
    host_wr(8'hA5);
    chk_flags(1'b1, 1'b1, 1'b0, "R5 mono8 complete");
    host_wr(8'h33);
    chk(buf_stale === 1'b0, "R5 extra write while full", {31'd0, buf_stale}, 32'h0);
    dac_pulse();
    chk(play_data === 32'h00A5_0000, "R9 R5 mono8 sample", play_data, 32'h00A5_0000);
    chk(buf_stale === 1'b1 && underrun === 1'b0, "R6 take mono8",
        {30'd0, buf_stale, underrun}, 32'h2);
    last_play = 32'h00A5_0000;
  endtask

  task automatic t_stereo16();
    logic [7:0] b [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
    logic [1:0] ul [4] = '{2'b01, 2'b11, 2'b00, 2'b10};
    set_mode(1'b1, 1'b1);
    for (int i = 0; i < 4; i++) begin
      chk_flags(ul[i][1], ul[i][0], 1'b1, $sformatf("R2 R3 R4 stereo16 slot %0d", i));
      host_wr(b[i]);
    end
    chk_flags(1'b0, 1'b1, 1'b0, "R4 R5 stereo16 full shows first byte");
    dac_pulse();
    chk(play_data === 32'h2211_4433, "R2 R6 R9 stereo16 sample", play_data, 32'h2211_4433);
    last_play = 32'h2211_4433;
  endtask

  task automatic t_stereo8();
    set_mode(1'b1, 1'b0);
    chk_flags(1'b1, 1'b1, 1'b1, "R2 R3 stereo8 left");
    host_wr(8'h5A);
    chk_flags(1'b1, 1'b0, 1'b1, "R2 R4 stereo8 right");
    host_wr(8'hC3);
    dac_pulse();
    chk(play_data === 32'h005A_00C3, "R2 R9 stereo8 sample", play_data, 32'h005A_00C3);
    last_play = 32'h005A_00C3;
  endtask

  task automatic t_mono16();
    set_mode(1'b0, 1'b1);
    chk_flags(1'b0, 1'b1, 1'b1, "R2 R3 mono16 low");
    host_wr(8'h01);
    chk_flags(1'b1, 1'b1, 1'b1, "R2 R3 mono16 high");
    host_wr(8'h80);
    dac_pulse();
    chk(play_data === 32'h8001_0000, "R2 R9 mono16 sample", play_data, 32'h8001_0000);
    last_play = 32'h8001_0000;
  endtask

  task automatic t_underrun();
    set_mode(1'b1, 1'b1);
    host_wr(8'hDE); host_wr(8'hAD);
    chk_flags(1'b0, 1'b0, 1'b1, "R2 partial at right low");
    dac_pulse();
    chk(play_data === last_play, "R7 resend previous", play_data, last_play);
    chk(underrun === 1'b1, "R7 underrun set", {31'd0, underrun}, 32'h1);
    chk_flags(1'b0, 1'b1, 1'b1, "R7 pointer reset");
    host_wr(8'h01); host_wr(8'h02); host_wr(8'h03); host_wr(8'h04);
    dac_pulse();
    chk(play_data === 32'h0201_0403, "R7 partial discarded", play_data, 32'h0201_0403);
    chk(underrun === 1'b0, "R6 underrun cleared", {31'd0, underrun}, 32'h0);
    last_play = 32'h0201_0403;
  endtask

  task automatic t_init();
    set_mode(1'b1, 1'b1);
    @(negedge clk); init_active = 1'b1;
    host_wr(8'h77); host_wr(8'h66);
    chk_flags(1'b0, 1'b1, 1'b1, "R8 writes locked during init");
    @(negedge clk); init_active = 1'b0;
    dac_pulse();
    chk(underrun === 1'b1 && play_data === last_play, "R8 nothing stored during init",
        play_data, last_play);
  endtask

  task automatic t_collide();
    set_mode(1'b0, 1'b0);
    host_wr(8'h9C);
    @(negedge clk); dac_req = 1'b1; wr_en = 1'b1; wr_data = 8'h42;
    @(negedge clk); dac_req = 1'b0; wr_en = 1'b0;
    chk(play_data === 32'h009C_0000, "R10 request takes sample", play_data, 32'h009C_0000);
    chk_flags(1'b1, 1'b1, 1'b1, "R10 colliding write dropped");
    host_wr(8'h10);
    repeat (3) @(negedge clk);
    chk(play_data === 32'h009C_0000, "R11 play_data holds without request",
        play_data, 32'h009C_0000);
    dac_pulse();
    chk(play_data === 32'h0010_0000, "R10 next sample clean", play_data, 32'h0010_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mono8();
    t_stereo16();
    t_stereo8();
    t_mono16();
    t_underrun();
    t_init();
    t_collide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule